// File: doc/BRIEF.md
# Single-Bin DFT Correlator

This block measures the content of one chosen frequency in a stream of signed audio samples, such as the output of a decimator behind a pulse-density microphone. A phase accumulator advances by a programmed step on every accepted sample. The top bits of the phase index a quarter-wave sine table, which yields a complex phasor cos(theta) - j*sin(theta). Each sample is multiplied by both parts of the phasor, and the two products are summed into separate real and imaginary accumulators. After a programmed number of samples, the two sums give the amplitude and phase of the bin.

A CPU drives the block through a small word-addressed register port. It writes the sample count and the phase step, then writes the start bit. When the last product has been summed, the block pulses a result strobe for one cycle and sets a sticky done flag. The complex result stays on the output ports and in readable registers until the next start.

Top module: `dft_bin_core`

## Requirements
- R1: After reset, res_valid_o is 0, the status word reads 0, the count and step registers read 0, and both results are 0.
- R2: The register map uses word addresses. 0 is control and status: writing bit 0 high starts a run, and reading returns done in bit 0 and busy in bit 1. 1 is the sample count (16 bits). 2 is the phase step (32 bits). 4 and 5 are the real result, low 32 bits then the upper 16 bits sign-extended. 6 and 7 are the imaginary result in the same layout. The count and step registers read back the value written.
- R3: A start clears the accumulators, the results and done, resets the phase to zero, and latches the sample count and the phase step.
- R4: Sample k of a run (k from 0) uses phase index i = bits 31..24 of k*step, taken modulo 2^32. The phasor parts are sin = round(32767*sin(2*pi*i/256)) and cos = the sin value at index i+64.
- R5: The real sum adds x*cos and the imaginary sum subtracts x*sin, using 48-bit two's-complement arithmetic. This holds for full-scale samples of -32768.
- R6: Suppose the n-th accepted sample of a run arrives in cycle t. Then res_valid_o is high for exactly one cycle, cycle t+2. The result appears on res_re_o and res_im_o and in the registers in that same cycle, and done reads 1 from then on.
- R7: Samples presented while the block is not busy, or in the cycle of a start write, are not accepted. They do not change the results, the busy or done state, or the count of samples in the run.
- R8: A start with a count of 0 completes at once: res_valid_o pulses in the cycle after the start, done is set, and the result is zero.
- R9: A start in the middle of a run abandons that run, including a start in the cycle after its last sample. No result strobe appears for the abandoned run, and a new run begins.
- R10: The results hold their values between a completion and the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from address) |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | 16 | Signed audio sample |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_re_o | output | 48 | Real part of the result |
| res_im_o | output | 48 | Imaginary part of the result |

## Verification
A start write can coincide with two other events: a sample strobe in the same cycle, or the final product landing in the accumulators. The bench provokes both. It holds the sample strobe high through a restart write, and it issues a start in the cycle right after the last sample of a run. A behavioural model gives start priority in both cases. It compares the strobe, the result ports and the status word on every clock. The bench also counts result pulses, so that a dropped sample shows up as a missing or an extra completion.

// File: rtl/dft_bin_pkg.sv
`timescale 1ns/1ps
package dft_bin_pkg;
  typedef enum logic [2:0] {
    RA_CTRL  = 3'd0,
    RA_LEN   = 3'd1,
    RA_STEP  = 3'd2,
    RA_RSVD  = 3'd3,
    RA_RE_LO = 3'd4,
    RA_RE_HI = 3'd5,
    RA_IM_LO = 3'd6,
    RA_IM_HI = 3'd7
  } reg_addr_e;

  localparam int unsigned CTRL_START_BIT = 0;
  localparam int unsigned STAT_DONE_BIT  = 0;
  localparam int unsigned STAT_BUSY_BIT  = 1;
endpackage

// File: rtl/dft_bin_regs.sv
`timescale 1ns/1ps
module dft_bin_regs
  import dft_bin_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PHASE_W = 32,
  parameter int unsigned ACC_W   = 48
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [2:0]         addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  input  logic               busy_i,
  input  logic               done_i,
  input  logic [ACC_W-1:0]   res_re_i,
  input  logic [ACC_W-1:0]   res_im_i,
  output logic               start_o,
  output logic [CNT_W-1:0]   len_o,
  output logic [PHASE_W-1:0] step_o
);
  localparam int unsigned HI_W = ACC_W - DW;

  reg_addr_e  addr;
  logic [CNT_W-1:0]   len_q;
  logic [PHASE_W-1:0] step_q;

  assign addr    = reg_addr_e'(addr_i);
  assign start_o = we_i && (addr == RA_CTRL) && wdata_i[CTRL_START_BIT];
  assign len_o   = len_q;
  assign step_o  = step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= '0;
      step_q <= '0;
    end else if (we_i) begin
      if (addr == RA_LEN)  len_q  <= wdata_i[CNT_W-1:0];
      if (addr == RA_STEP) step_q <= wdata_i[PHASE_W-1:0];
    end
  end

  logic signed [HI_W-1:0] re_hi, im_hi;
  assign re_hi = res_re_i[ACC_W-1:DW];
  assign im_hi = res_im_i[ACC_W-1:DW];

  always_comb begin
    rdata_o = '0;
    unique case (addr)
      RA_CTRL: begin
        rdata_o[STAT_DONE_BIT] = done_i;
        rdata_o[STAT_BUSY_BIT] = busy_i;
      end
      RA_LEN:   rdata_o = DW'(len_q);
      RA_STEP:  rdata_o = DW'(step_q);
      RA_RSVD:  rdata_o = '0;
      RA_RE_LO: rdata_o = res_re_i[DW-1:0];
      RA_RE_HI: rdata_o = DW'(re_hi);
      RA_IM_LO: rdata_o = res_im_i[DW-1:0];
      RA_IM_HI: rdata_o = DW'(im_hi);
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dft_bin_phasor.sv
`timescale 1ns/1ps
module dft_bin_phasor #(
  parameter int unsigned PHASE_W  = 32,
  parameter int unsigned LUT_BITS = 6,
  parameter int unsigned COEF_W   = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic [PHASE_W-1:0]       step_i,
  input  logic                     adv_i,
  output logic signed [COEF_W-1:0] cos_o,
  output logic signed [COEF_W-1:0] sin_o
);
  localparam int unsigned IDX_W = LUT_BITS + 2;
  localparam int unsigned LUT_N = 1 << LUT_BITS;
  localparam int          AMP   = (1 << (COEF_W - 1)) - 1;
  localparam real         HALF_PI = 1.5707963267948966;

  logic signed [COEF_W-1:0] rom [LUT_N];

  // first quadrant of the sine, index 0 .. LUT_N-1
  initial begin
    for (int i = 0; i < LUT_N; i++)
      rom[i] = COEF_W'($rtoi(real'(AMP) * $sin(HALF_PI * real'(i) / real'(LUT_N)) + 0.5));
  end

  logic [PHASE_W-1:0]       phase_q, step_q;
  logic [IDX_W-1:0]         idx;
  logic [1:0]               quad;
  logic [LUT_BITS-1:0]      k;
  logic signed [COEF_W-1:0] mag_a, mag_b, cos_c, sin_c;

  assign idx  = phase_q[PHASE_W-1 -: IDX_W];
  assign quad = idx[IDX_W-1 -: 2];
  assign k    = idx[LUT_BITS-1:0];

  always_comb begin
    mag_a = rom[k];
    mag_b = (k == '0) ? COEF_W'(AMP) : rom[LUT_BITS'(LUT_N - int'(k))];
    unique case (quad)
      2'd0: begin sin_c =  mag_a; cos_c =  mag_b; end
      2'd1: begin sin_c =  mag_b; cos_c = -mag_a; end
      2'd2: begin sin_c = -mag_a; cos_c = -mag_b; end
      default: begin sin_c = -mag_b; cos_c = mag_a; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      step_q  <= '0;
      cos_o   <= '0;
      sin_o   <= '0;
    end else if (clr_i) begin
      phase_q <= '0;
      step_q  <= step_i;
    end else if (adv_i) begin
      cos_o   <= cos_c;
      sin_o   <= sin_c;
      phase_q <= phase_q + step_q;
    end
  end
endmodule

// File: rtl/dft_bin_mac.sv
`timescale 1ns/1ps
module dft_bin_mac #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned COEF_W   = 16,
  parameter int unsigned ACC_W    = 48
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic                       en_i,
  input  logic                       last_i,
  input  logic signed [SAMPLE_W-1:0] x_i,
  input  logic signed [COEF_W-1:0]   cos_i,
  input  logic signed [COEF_W-1:0]   sin_i,
  output logic                       fin_o,
  output logic [ACC_W-1:0]           res_re_o,
  output logic [ACC_W-1:0]           res_im_o
);
  localparam int unsigned PROD_W = SAMPLE_W + COEF_W;

  logic signed [PROD_W-1:0] p_re, p_im;
  logic signed [ACC_W-1:0]  acc_re_q, acc_im_q, sum_re, sum_im;

  always_comb begin
    p_re   = x_i * cos_i;
    p_im   = x_i * sin_i;
    sum_re = acc_re_q + ACC_W'(p_re);
    sum_im = acc_im_q - ACC_W'(p_im);  // conjugate phasor
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_re_q <= '0;
      acc_im_q <= '0;
      res_re_o <= '0;
      res_im_o <= '0;
      fin_o    <= 1'b0;
    end else if (clr_i) begin
      acc_re_q <= '0;
      acc_im_q <= '0;
      res_re_o <= '0;
      res_im_o <= '0;
      fin_o    <= 1'b0;
    end else begin
      fin_o <= en_i && last_i;
      if (en_i) begin
        acc_re_q <= sum_re;
        acc_im_q <= sum_im;
      end
      if (en_i && last_i) begin
        res_re_o <= sum_re;
        res_im_o <= sum_im;
      end
    end
  end
endmodule

// File: rtl/dft_bin_core.sv
`timescale 1ns/1ps
module dft_bin_core #(
  parameter int unsigned DW       = 32,
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned COEF_W   = 16,
  parameter int unsigned ACC_W    = 48,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned PHASE_W  = 32,
  parameter int unsigned LUT_BITS = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [2:0]          reg_addr_i,
  input  logic [DW-1:0]       reg_wdata_i,
  output logic [DW-1:0]       reg_rdata_o,
  input  logic                smp_valid_i,
  input  logic [SAMPLE_W-1:0] smp_data_i,
  output logic                res_valid_o,
  output logic [ACC_W-1:0]    res_re_o,
  output logic [ACC_W-1:0]    res_im_o
);
  logic                       start_p, accept;
  logic [CNT_W-1:0]           len_w, cnt_q;
  logic [PHASE_W-1:0]         step_w;
  logic                       busy_q, done_q, zero_fin_q;
  logic                       s1_v_q, s1_last_q;
  logic signed [SAMPLE_W-1:0] s1_x_q;
  logic signed [COEF_W-1:0]   cos_w, sin_w;
  logic                       mac_fin;

  dft_bin_regs #(
    .DW(DW), .CNT_W(CNT_W), .PHASE_W(PHASE_W), .ACC_W(ACC_W)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .busy_i(busy_q), .done_i(done_q), .res_re_i(res_re_o), .res_im_i(res_im_o),
    .start_o(start_p), .len_o(len_w), .step_o(step_w)
  );

  // start wins over a sample in the same cycle
  assign accept = busy_q && smp_valid_i && !start_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      zero_fin_q <= 1'b0;
      cnt_q      <= '0;
      s1_v_q     <= 1'b0;
      s1_last_q  <= 1'b0;
      s1_x_q     <= '0;
    end else if (start_p) begin
      busy_q     <= (len_w != '0);
      cnt_q      <= len_w;
      zero_fin_q <= (len_w == '0);
      done_q     <= (len_w == '0);
      s1_v_q     <= 1'b0;
    end else begin
      zero_fin_q <= 1'b0;
      s1_v_q     <= accept;
      if (accept) begin
        s1_x_q    <= smp_data_i;
        s1_last_q <= (cnt_q == CNT_W'(1));
        cnt_q     <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
      end
      if (s1_v_q && s1_last_q) done_q <= 1'b1;
    end
  end

  dft_bin_phasor #(
    .PHASE_W(PHASE_W), .LUT_BITS(LUT_BITS), .COEF_W(COEF_W)
  ) u_phasor (
    .clk_i, .rst_ni,
    .clr_i(start_p), .step_i(step_w), .adv_i(accept),
    .cos_o(cos_w), .sin_o(sin_w)
  );

  dft_bin_mac #(
    .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .ACC_W(ACC_W)
  ) u_mac (
    .clk_i, .rst_ni,
    .clr_i(start_p), .en_i(s1_v_q), .last_i(s1_last_q),
    .x_i(s1_x_q), .cos_i(cos_w), .sin_i(sin_w),
    .fin_o(mac_fin), .res_re_o(res_re_o), .res_im_o(res_im_o)
  );

  assign res_valid_o = mac_fin || zero_fin_q;
endmodule

// File: rtl/dft_bin_core_chk.sv
`timescale 1ns/1ps
module dft_bin_core_chk #(
  parameter int unsigned ACC_W = 48,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_p,
  input logic [CNT_W-1:0] len,
  input logic             busy,
  input logic             done,
  input logic             res_valid,
  input logic [ACC_W-1:0] res_re,
  input logic [ACC_W-1:0] res_im
);
  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid && !start_p |=> !res_valid);

  a_r6_done_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid |-> done);

  a_r3_start_clears_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_p |=> (done == ($past(len) == '0)));

  a_r7_idle_stays_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy && !start_p |=> !busy);

  a_r8_zero_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_p && (len == '0) |=> res_valid && !busy);

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_p |=> ($stable(res_re) && $stable(res_im)) || res_valid);
endmodule

bind dft_bin_core dft_bin_core_chk #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_p(start_p), .len(len_w),
  .busy(busy_q), .done(done_q), .res_valid(res_valid_o),
  .res_re(res_re_o), .res_im(res_im_o)
);

// File: tb/dft_bin_core_tb_top.sv
`timescale 1ns/1ps
module dft_bin_core_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        sv = 1'b0;
  logic [15:0] sd = '0;
  logic        rv;
  logic [47:0] rre, rim;

  always #2.5 clk = ~clk;

  dft_bin_core dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .smp_valid_i(sv), .smp_data_i(sd),
    .res_valid_o(rv), .res_re_o(rre), .res_im_o(rim)
  );

  int n_tests = 0, n_fail = 0, pulses = 0;

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sinv(int idx);
    real v;
    v = 32767.0 * $sin(2.0 * 3.141592653589793 * real'(idx % 256) / 256.0);
    return $rtoi($floor(v + 0.5));
  endfunction

  // behavioural reference model
  longint      m_are, m_aim, m_rre, m_rim;
  bit          m_busy, m_done, m_pend, m_plast, m_vexp, m_st, m_nv;
  int          m_rem, m_px, m_pidx;
  int unsigned m_phase, m_step, m_lenreg, m_stepreg;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_are = 0; m_aim = 0; m_rre = 0; m_rim = 0;
      m_busy = 0; m_done = 0; m_pend = 0; m_plast = 0; m_vexp = 0;
      m_rem = 0; m_phase = 0; m_step = 0; m_lenreg = 0; m_stepreg = 0;
    end else begin
      m_st = we && addr == 3'd0 && wdata[0];
      m_nv = 0;
      if (m_st) begin
        m_are = 0; m_aim = 0; m_rre = 0; m_rim = 0; m_pend = 0;
        m_rem = int'(m_lenreg); m_busy = (m_lenreg != 0); m_done = (m_lenreg == 0);
        m_nv = (m_lenreg == 0); m_phase = 0; m_step = m_stepreg;
      end else begin
        if (m_pend) begin
          m_are += longint'(m_px) * sinv(m_pidx + 64);
          m_aim -= longint'(m_px) * sinv(m_pidx);
          if (m_plast) begin
            m_rre = m_are; m_rim = m_aim; m_done = 1; m_nv = 1;
          end
          m_pend = 0;
        end
        if (m_busy && sv) begin
          m_pend = 1; m_px = int'($signed(sd)); m_pidx = int'(m_phase >> 24);
          m_phase += m_step; m_rem--; m_plast = (m_rem == 0);
          if (m_rem == 0) m_busy = 0;
        end
      end
      if (we && addr == 3'd1) m_lenreg = {16'd0, wdata[15:0]};
      if (we && addr == 3'd2) m_stepreg = wdata;
      m_vexp = m_nv;
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (rv) pulses++;
      check(rv == m_vexp, "R6 res_valid", longint'(rv), longint'(m_vexp));
      check(longint'($signed(rre)) == m_rre, "R10 res_re port", longint'($signed(rre)), m_rre);
      check(longint'($signed(rim)) == m_rim, "R10 res_im port", longint'($signed(rim)), m_rim);
      if (addr == 3'd0 && !we) begin
        check(rdata[0] == m_done, "R6 done flag", longint'(rdata[0]), longint'(m_done));
        check(rdata[1] == m_busy, "R7 busy flag", longint'(rdata[1]), longint'(m_busy));
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1; v = rdata; addr = '0;
  endtask

  task automatic rd_res(input bit im, output longint v);
    logic [31:0] lo, hi;
    rd(im ? 3'd6 : 3'd4, lo);
    rd(im ? 3'd7 : 3'd5, hi);
    v = longint'($signed({hi[15:0], lo}));
  endtask

  function automatic logic [15:0] smp_val(int mode, int i);
    if (mode == 0) return 16'(100 * (i + 1));
    if (mode == 2) return 16'h8000;
    return 16'($urandom);
  endfunction

  task automatic feed(int n, bit gaps, int mode, bit start_after);
    for (int i = 0; i < n; i++) begin
      if (gaps) begin
        int g = int'($urandom % 3);
        repeat (g) begin @(negedge clk); sv = 1'b0; end
      end
      @(negedge clk); sv = 1'b1; sd = smp_val(mode, i);
    end
    @(negedge clk); sv = 1'b0;
    if (start_after) begin
      we = 1'b1; addr = 3'd0; wdata = 32'd1;
      @(negedge clk); we = 1'b0; wdata = '0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    longint r;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, v); check(v == 0, "R1 status", v, 0);
    rd(3'd1, v); check(v == 0, "R1 count reg", v, 0);
    rd(3'd2, v); check(v == 0, "R1 step reg", v, 0);
    rd_res(0, r); check(r == 0, "R1 result re", r, 0);
    check(rv == 0, "R1 res_valid", rv, 0);

    // R2 map readback
    wr(3'd1, 32'd5); wr(3'd2, 32'h4000_0000);
    rd(3'd1, v); check(v == 5, "R2 count readback", v, 5);
    rd(3'd2, v); check(v == 32'h4000_0000, "R2 step readback", v, 32'h4000_0000);

    // R7 idle samples
    feed(6, 0, 1, 0);
    rd(3'd0, v); check(v == 0, "R7 idle status", v, 0);
    check(pulses == 0, "R7 idle no pulse", pulses, 0);

    // R4 R5 R6 quarter-turn run
    pulses = 0;
    wr(3'd0, 32'd1); feed(5, 0, 0, 0); repeat (4) @(negedge clk);
    check(pulses == 1, "R6 one pulse", pulses, 1);
    rd_res(0, r); check(r == 64'sd9830100, "R4 R5 real sum", r, 9830100);
    rd_res(1, r); check(r == 64'sd6553400, "R4 R5 imag sum", r, 6553400);
    rd(3'd0, v); check(v == 1, "R6 done sticky", v, 1);

    // R10 hold
    repeat (20) @(negedge clk);
    rd_res(0, r); check(r == 64'sd9830100, "R10 held result", r, 9830100);

    // R3 start clears
    wr(3'd0, 32'd1);
    rd_res(0, r); check(r == 0, "R3 result cleared", r, 0);
    rd(3'd0, v); check(v == 2, "R3 busy, done cleared", v, 2);
    feed(5, 1, 1, 0); repeat (4) @(negedge clk);

    // R4 odd step, gapped stream
    pulses = 0;
    wr(3'd1, 32'd37); wr(3'd2, 32'h0123_4567); wr(3'd0, 32'd1);
    feed(37, 1, 1, 0); repeat (4) @(negedge clk);
    check(pulses == 1, "R4 gapped run pulse", pulses, 1);
    rd_res(1, r); check(r == m_rim, "R4 gapped imag", r, m_rim);

    // R5 full-scale negative samples
    wr(3'd1, 32'd300); wr(3'd2, 32'h0080_0000); wr(3'd0, 32'd1);
    feed(300, 0, 2, 0); repeat (4) @(negedge clk);
    rd_res(0, r); check(r == m_rre && r != 0, "R5 full-scale real", r, m_rre);
    rd_res(1, r); check(r == m_rim, "R5 full-scale imag", r, m_rim);

    // R8 zero count
    wr(3'd1, 32'd0); pulses = 0; wr(3'd0, 32'd1); repeat (3) @(negedge clk);
    check(pulses == 1, "R8 zero-count pulse", pulses, 1);
    rd(3'd0, v); check(v == 1, "R8 done", v, 1);
    rd_res(0, r); check(r == 0, "R8 zero result", r, 0);

    // R9 restart mid-run, sample held during the start write (R7)
    wr(3'd1, 32'd10); wr(3'd2, 32'h0300_0000); wr(3'd0, 32'd1);
    feed(3, 0, 1, 0);
    pulses = 0;
    @(negedge clk); sv = 1'b1; sd = 16'h1234;
    we = 1'b1; addr = 3'd0; wdata = 32'd1;
    @(negedge clk); we = 1'b0; wdata = '0; sv = 1'b0;
    feed(9, 0, 1, 0); repeat (4) @(negedge clk);
    check(pulses == 0, "R7 start-cycle sample dropped", pulses, 0);
    feed(1, 0, 1, 0); repeat (4) @(negedge clk);
    check(pulses == 1, "R9 restarted run completes", pulses, 1);

    // R9 start in the cycle after the last sample
    wr(3'd1, 32'd4); wr(3'd0, 32'd1); pulses = 0;
    feed(4, 0, 1, 1); repeat (4) @(negedge clk);
    check(pulses == 0, "R9 abandoned run silent", pulses, 0);
    rd(3'd0, v); check(v == 2, "R9 new run busy", v, 2);
    feed(4, 0, 1, 0); repeat (4) @(negedge clk);
    check(pulses == 1, "R9 new run pulse", pulses, 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule